// File: doc/BRIEF.md
# Triggered Latch Gate Sequencer

This block sits between an external event trigger and a chain of parallel-load shift registers that hold discriminator hits. A rising trigger edge that arrives while nothing is busy opens an active-low gate window. Partway through that window, after a programmable wait that gives slow analog pulses time to cross threshold, the block drives a short active-low load strobe that copies the hits into the registers.

When the window closes, a positive interrupt pulse tells the readout controller that an event has been captured. From then on a shift enable lets the shift clock reach the registers. No shift clock runs during the live window. The block keeps its own busy high from trigger acceptance until the controller has raised and then dropped its readout busy. It ORs the two busies onto one output that vetoes new triggers.

All delays and widths are counted in system-clock cycles and set by parameters. The trigger is synchronised and edge-detected inside the block.

Top module: `latch_gate_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, gateN=1, loadN=1, irq=0 and shiftEn=0; busy then equals ctrlBusy.
- R2: A trigger rise that is accepted drives gateN low on the third rising clock edge after trigIn goes high (two synchroniser stages plus the state register). gateN stays low for exactly GATE_CYC cycles.
- R3: loadN is low for exactly LOAD_CYC cycles. It first goes low DELAY_CYC cycles after gateN fell. It is only ever low while gateN is low.
- R4: irq is high for exactly IRQ_CYC cycles, starting in the cycle right after gateN returns high, and is never high while gateN is low.
- R5: shiftEn is 0 while gateN is low. It is 1 from the end of the gate window until the first cycle in which ctrlBusy is sampled low after having been sampled high.
- R6: busy is the OR of ctrlBusy and a local busy. The local busy is high from the cycle gateN falls until the block returns to idle after the controller's busy falls.
- R7: A trigger rise that is seen while busy is high starts no sequence, whether the busy comes from the local logic or from ctrlBusy.
- R8: A trigger held high starts only one sequence. A new sequence needs trigIn to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | External event trigger, asynchronous, rising edge starts a sequence |
| ctrlBusy | input | 1 | Readout-busy level from the downstream controller |
| gateN | output | 1 | Active-low gate window toward the shift-register chain |
| loadN | output | 1 | Active-low parallel-load strobe inside the gate window |
| irq | output | 1 | Positive event-ready pulse to the readout controller |
| shiftEn | output | 1 | Enable that releases the shift clock after the latch |
| busy | output | 1 | Combined busy that vetoes further triggers |

## Verification
The bench builds the block with DELAY_CYC=3, LOAD_CYC=2, GATE_CYC=8 and IRQ_CYC=2, instead of the defaults of several hundred cycles. With these values a whole sequence fits in a dozen cycles, so its output pattern can be compared cycle by cycle against a table. The short windows also make the edge cases reachable within a few cycles: the strobe sits at a fixed interior offset, a retrigger lands inside the gate, and the interrupt ends one cycle before the wait for the controller begins. The default synchroniser depth of two is kept, so the three-edge trigger latency is checked as built.

// File: rtl/latch_gate_seq_pkg.sv
package latch_gate_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GATE  = 3'd1,
    ST_IRQ   = 3'd2,
    ST_ARM   = 3'd3,
    ST_DRAIN = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntEn;
    logic inGate;
  } seqStrobe_t;

endpackage

// File: rtl/latch_gate_seq_datapath.sv
module latch_gate_seq_datapath
  import latch_gate_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_CYC   = 250,
  parameter int LOAD_CYC    = 25,
  parameter int GATE_CYC    = 500,
  parameter int IRQ_CYC     = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trigIn,
  input  seqStrobe_t strobe,
  output logic       trigEdge,
  output logic       gateDone,
  output logic       irqDone,
  output logic       loadN
);

  localparam int MAX_CYC = (GATE_CYC > IRQ_CYC) ? GATE_CYC : IRQ_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] GATE_LAST = CNT_W'(GATE_CYC - 1);
  localparam logic [CNT_W-1:0] IRQ_LAST  = CNT_W'(IRQ_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_LO   = CNT_W'(DELAY_CYC);
  localparam logic [CNT_W-1:0] LOAD_HI   = CNT_W'(DELAY_CYC + LOAD_CYC);

  // synchroniser stages plus one history flop for edge detection
  logic [SYNC_STAGES:0] trigPipe;
  logic [CNT_W-1:0]     cycCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      trigPipe <= '0;
    end else begin
      trigPipe <= {trigPipe[SYNC_STAGES-1:0], trigIn};
    end
  end

  assign trigEdge = trigPipe[SYNC_STAGES-1] & ~trigPipe[SYNC_STAGES];

  // one counter times gate, strobe and interrupt in turn
  always_ff @(posedge clk) begin
    if (rst) begin
      cycCnt <= '0;
    end else if (strobe.cntClr) begin
      cycCnt <= '0;
    end else if (strobe.cntEn) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  assign gateDone = (cycCnt == GATE_LAST);
  assign irqDone  = (cycCnt == IRQ_LAST);
  assign loadN    = ~(strobe.inGate && (cycCnt >= LOAD_LO) && (cycCnt < LOAD_HI));

endmodule

// File: rtl/latch_gate_seq_ctrl.sv
module latch_gate_seq_ctrl
  import latch_gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       trigEdge,
  input  logic       gateDone,
  input  logic       irqDone,
  input  logic       ctrlBusy,
  output seqStrobe_t strobe,
  output logic       gateN,
  output logic       irq,
  output logic       shiftEn,
  output logic       localBusy
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext     = state;
    strobe.cntClr = 1'b0;
    strobe.cntEn  = 1'b0;
    strobe.inGate = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (trigEdge && !ctrlBusy) begin
          stateNext     = ST_GATE;
          strobe.cntClr = 1'b1;
        end
      end
      ST_GATE: begin
        strobe.inGate = 1'b1;
        strobe.cntEn  = 1'b1;
        if (gateDone) begin
          stateNext     = ST_IRQ;
          strobe.cntClr = 1'b1;
        end
      end
      ST_IRQ: begin
        strobe.cntEn = 1'b1;
        if (irqDone) stateNext = ST_ARM;
      end
      ST_ARM: begin
        if (ctrlBusy) stateNext = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!ctrlBusy) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign gateN     = (state != ST_GATE);
  assign irq       = (state == ST_IRQ);
  assign shiftEn   = (state == ST_IRQ) || (state == ST_ARM) || (state == ST_DRAIN);
  assign localBusy = (state != ST_IDLE);

endmodule

// File: rtl/latch_gate_seq.sv
module latch_gate_seq
  import latch_gate_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_CYC   = 250,
  parameter int LOAD_CYC    = 25,
  parameter int GATE_CYC    = 500,
  parameter int IRQ_CYC     = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic trigIn,
  input  logic ctrlBusy,
  output logic gateN,
  output logic loadN,
  output logic irq,
  output logic shiftEn,
  output logic busy
);

  seqStrobe_t strobe;
  logic       trigEdge;
  logic       gateDone;
  logic       irqDone;
  logic       localBusy;

  latch_gate_seq_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DELAY_CYC  (DELAY_CYC),
    .LOAD_CYC   (LOAD_CYC),
    .GATE_CYC   (GATE_CYC),
    .IRQ_CYC    (IRQ_CYC)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .trigIn  (trigIn),
    .strobe  (strobe),
    .trigEdge(trigEdge),
    .gateDone(gateDone),
    .irqDone (irqDone),
    .loadN   (loadN)
  );

  latch_gate_seq_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .trigEdge (trigEdge),
    .gateDone (gateDone),
    .irqDone  (irqDone),
    .ctrlBusy (ctrlBusy),
    .strobe   (strobe),
    .gateN    (gateN),
    .irq      (irq),
    .shiftEn  (shiftEn),
    .localBusy(localBusy)
  );

  assign busy = localBusy | ctrlBusy;

endmodule

// File: rtl/latch_gate_seq_chk.sv
module latch_gate_seq_chk (
  input logic clk,
  input logic rst,
  input logic trigIn,
  input logic ctrlBusy,
  input logic gateN,
  input logic loadN,
  input logic irq,
  input logic shiftEn,
  input logic busy
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gateN && loadN && !irq && !shiftEn));

  // R3
  load_inside_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !loadN |-> !gateN);

  // R4
  irq_follows_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(gateN) == 1'b0));

  // R4
  irq_gate_apart_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> gateN);

  // R5
  shift_held_live_chk: assert property (@(posedge clk) disable iff (rst)
    !gateN |-> !shiftEn);

  // R6
  busy_covers_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq || shiftEn || !gateN || ctrlBusy) |-> busy);

  // R7
  start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gateN) |-> ($past(busy) == 1'b0));

endmodule

bind latch_gate_seq latch_gate_seq_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .trigIn  (trigIn),
  .ctrlBusy(ctrlBusy),
  .gateN   (gateN),
  .loadN   (loadN),
  .irq     (irq),
  .shiftEn (shiftEn),
  .busy    (busy)
);

// File: tb/test_latch_gate_seq.sv
module test_latch_gate_seq;

  localparam int DLY = 3;
  localparam int LDW = 2;
  localparam int GTW = 8;
  localparam int IQW = 2;
  localparam int SEQ_LEN = 12;

  // per-cycle expectation after acceptance: {gateN, loadN, irq, shiftEn, busy}
  localparam logic [4:0] SEQ_EXP [SEQ_LEN] = '{
    5'b01001, 5'b01001, 5'b01001, 5'b00001, 5'b00001, 5'b01001,
    5'b01001, 5'b01001, 5'b11111, 5'b11111, 5'b11011, 5'b11011
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trigIn = 1'b0;
  logic ctrlBusy = 1'b0;
  logic gateN, loadN, irq, shiftEn, busy;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  latch_gate_seq #(
    .SYNC_STAGES(2),
    .DELAY_CYC  (DLY),
    .LOAD_CYC   (LDW),
    .GATE_CYC   (GTW),
    .IRQ_CYC    (IQW)
  ) i_latch_gate_seq (
    .clk     (clk),
    .rst     (rst),
    .trigIn  (trigIn),
    .ctrlBusy(ctrlBusy),
    .gateN   (gateN),
    .loadN   (loadN),
    .irq     (irq),
    .shiftEn (shiftEn),
    .busy    (busy)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOuts(input string req, input logic [4:0] expv);
    logic [4:0] act;
    act = {gateN, loadN, irq, shiftEn, busy};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s outputs gateN/loadN/irq/shiftEn/busy act=%b exp=%b", req, act, expv);
    end
  endtask

  task automatic checkVal(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    finishRun();
  end

  initial begin
    int gateCnt, loadCnt, loadFirst, irqCnt;
    @(negedge clk);
    // R1 reset state, busy follows controller
    tick();
    checkOuts("R1", 5'b11000);
    ctrlBusy = 1'b1;
    tick();
    checkOuts("R1", 5'b11001);
    ctrlBusy = 1'b0;
    rst = 1'b0;
    tick();
    checkOuts("R1", 5'b11000);

    // R2 R3 R4 R5 R6 table walk; R7 retrigger inside the gate
    trigIn = 1'b1;
    tick(); tick(); tick();
    for (int i = 0; i < SEQ_LEN; i++) begin
      checkOuts($sformatf("R2/R3/R4 seq step %0d", i), SEQ_EXP[i]);
      if (i == 3) trigIn = 1'b0;
      if (i == 4) trigIn = 1'b1;
      tick();
    end
    // R5 waiting for controller: shift still enabled
    ctrlBusy = 1'b1;
    tick();
    checkOuts("R5", 5'b11011);
    tick();
    checkOuts("R5", 5'b11011);
    ctrlBusy = 1'b0;
    tick();
    checkOuts("R6", 5'b11000);

    // R8 trigger still held high: no new sequence; R7 retrigger ignored
    for (int i = 0; i < 10; i++) begin
      tick();
      checkOuts("R8", 5'b11000);
    end

    // R7 trigger while controller busy in idle
    trigIn = 1'b0;
    tick(); tick(); tick();
    ctrlBusy = 1'b1;
    trigIn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      checkOuts("R7", 5'b11001);
    end
    ctrlBusy = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      checkOuts("R7", 5'b11000);
    end

    // R2 R3 R4 measured windows on a fresh trigger
    trigIn = 1'b0;
    tick(); tick(); tick();
    trigIn = 1'b1;
    tick(); tick();
    checkVal("R2 gate still high before third edge", gateN, 1);
    tick();
    checkVal("R2 gate low at third edge", gateN, 0);
    gateCnt = 0; loadCnt = 0; loadFirst = -1; irqCnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (!gateN) gateCnt++;
      if (!loadN) begin
        if (loadFirst < 0) loadFirst = i;
        loadCnt++;
      end
      if (irq) irqCnt++;
      tick();
    end
    checkVal("R2 gate width", gateCnt, GTW);
    checkVal("R3 load width", loadCnt, LDW);
    checkVal("R3 load offset", loadFirst, DLY);
    checkVal("R4 irq width", irqCnt, IQW);
    checkVal("R5 shift enabled awaiting controller", shiftEn, 1);
    ctrlBusy = 1'b1;
    tick();
    ctrlBusy = 1'b0;
    tick();
    checkOuts("R6", 5'b11000);

    // R1 reset in the middle of a gate window
    trigIn = 1'b0;
    tick(); tick(); tick();
    trigIn = 1'b1;
    tick(); tick(); tick(); tick(); tick();
    checkVal("R2 gate open before reset", gateN, 0);
    rst = 1'b1;
    tick();
    checkOuts("R1", 5'b11000);
    rst = 1'b0;
    tick();
    checkOuts("R1", 5'b11000);

    finishRun();
  end

endmodule